// File: doc/BRIEF.md
# Double-Buffered PWM Channel

One 8-bit pulse-width channel. A counter advances on each clock-enable pulse from an external prescaler. Comparing the counter with an active duty value and an active period value produces one output pin. The counter can run in left-aligned form (it counts up and wraps) or in center-aligned form (it counts up to the period and then back down to zero).

Period and duty writes land in a buffer. The values the comparators use are taken from that buffer only at a cycle boundary, on a counter write, or while the channel is idle. Software can therefore retune the waveform at any time and the pin shows either the old waveform or the new one, never a mix of the two. A polarity input chooses whether each cycle opens high or low, and so whether the duty value counts the high time or the low time.

Top module: `pwm_chan`

## Requirements
- R1: While the synchronized enable is low, the counter value on `cnt_o` holds, whatever happens on `tick_i`.
- R2: `en_i` is sampled only in a cycle where `tick_i` is high. A change of `en_i` without a tick does not start or stop counting.
- R3: The enabled output is `pol_i` during the active phase and `!pol_i` otherwise. The active phase is counter < duty, which makes the first phase of each cycle read high for `pol_i`=1 and low for `pol_i`=0. `pwm_o` is registered one clock after the counter state it reflects.
- R4: While enabled, a period or duty write takes effect only at the next wrap, on a counter write, or when the channel is disabled. The counter and output continue on the old values until then.
- R5: While disabled, a period or duty write updates the active value immediately, so the next enabled cycle uses it.
- R6: A pulse on `cnt_we_i` sets the counter to 0 on the next clock, sets the direction to up, and loads the buffered period and duty into the active values.
- R7: Left-aligned (`center_i`=0): on each enabled tick the counter goes from c to c+1 while c < period. When c >= period it goes to 0 and the buffered values are loaded.
- R8: Center-aligned (`center_i`=1): the counter counts up to the period and then down. A tick that would bring it to 0 or below sets it to 0 with direction up and loads the buffered values. With period 0 it stays at 0.
- R9: Duty 0 keeps the output at `!pol_i` for the whole cycle. A nonzero duty >= period keeps it at `pol_i` for the whole cycle.
- R10: While disabled, `pwm_o` is `!pol_i` one clock later.
- R11: `cnt_o` always shows the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock-enable pulse from the prescaler |
| en_i | input | 1 | Channel enable request, taken on a tick |
| pol_i | input | 1 | Level of the first phase of each cycle |
| center_i | input | 1 | 1 selects center-aligned counting |
| per_we_i | input | 1 | Period write strobe |
| per_wdata_i | input | 8 | Period write value |
| duty_we_i | input | 1 | Duty write strobe |
| duty_wdata_i | input | 8 | Duty write value |
| cnt_we_i | input | 1 | Counter write strobe (clears and reloads) |
| cnt_o | output | 8 | Counter value |
| pwm_o | output | 1 | PWM output |

## Verification
The bench sweeps both alignments, both polarities, several small periods and every duty from 0 to one past the period, at tick rates of one in one and one in three. It compares the pin and the counter with an arithmetic model on every clock.

Directed runs cover the following, with the failure each one catches:
- A write while the channel is enabled. A design that skips the buffer changes the waveform mid-cycle.
- A counter write in mid-period. A design that fails to reload keeps the stale duty after the clear.
- A disable in mid-count. A design that keeps counting, or does not park the pin at the inactive level, is caught.
- An enable toggled without a tick. A design without tick synchronization starts counting early.
- The endpoint duties. An off-by-one compare leaks a one-clock pulse for duty 0 or for duty equal to the period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {ALIGN_LEFT = 1'b0, ALIGN_CENTER = 1'b1} align_e;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         reload_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] buf_q, buf_d, act_q;

  assign buf_d = we_i ? wdata_i : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      if (!en_i)         act_q <= buf_d;  // idle: writes pass straight through
      else if (reload_i) act_q <= buf_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clr_i,
  input  align_e       align_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         reload_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d, wrap;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    wrap  = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
      wrap  = 1'b1;
    end else if (step_i) begin
      if (align_i == ALIGN_LEFT) begin
        if (cnt_q >= per_i) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (up_q && cnt_q < per_i) begin
        cnt_d = cnt_q + ONE;
      end else if (cnt_q <= ONE) begin
        cnt_d = '0;
        up_d  = 1'b1;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
        up_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = wrap;
endmodule

// File: rtl/pwm_level.sv
module pwm_level #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o
);
  logic active, pwm_q;

  // duty 0 never active; duty >= period active throughout
  assign active = (duty_i != '0) && ((cnt_i < duty_i) || (duty_i >= per_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= (en_i && active) ? pol_i : !pol_i;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic         center_i,
  input  logic         per_we_i,
  input  logic [W-1:0] per_wdata_i,
  input  logic         duty_we_i,
  input  logic [W-1:0] duty_wdata_i,
  input  logic         cnt_we_i,
  output logic [W-1:0] cnt_o,
  output logic         pwm_o
);
  logic         en_q, reload;
  logic [W-1:0] per_act, duty_act;
  align_e       align;

  assign align = center_i ? ALIGN_CENTER : ALIGN_LEFT;

  // enable changes only on a prescaler tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b0;
    else if (tick_i) en_q <= en_i;
  end

  pwm_shadow #(.W(W)) u_per (
    .clk_i, .rst_ni, .en_i(en_q), .we_i(per_we_i), .wdata_i(per_wdata_i),
    .reload_i(reload), .act_o(per_act)
  );

  pwm_shadow #(.W(W)) u_duty (
    .clk_i, .rst_ni, .en_i(en_q), .we_i(duty_we_i), .wdata_i(duty_wdata_i),
    .reload_i(reload), .act_o(duty_act)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .step_i(tick_i && en_q), .clr_i(cnt_we_i),
    .align_i(align), .per_i(per_act), .cnt_o(cnt_o), .reload_o(reload)
  );

  pwm_level #(.W(W)) u_lvl (
    .clk_i, .rst_ni, .en_i(en_q), .pol_i(pol_i), .cnt_i(cnt_o),
    .per_i(per_act), .duty_i(duty_act), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         en_q,
  input logic         pol_i,
  input logic         per_we_i,
  input logic [W-1:0] per_wdata_i,
  input logic         cnt_we_i,
  input logic         reload,
  input logic [W-1:0] per_act,
  input logic [W-1:0] duty_act,
  input logic [W-1:0] cnt_o,
  input logic         pwm_o
);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !cnt_we_i |=> $stable(cnt_o));

  p_en_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(en_q));

  p_buf_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && !reload && !cnt_we_i |=> $stable(per_act) && $stable(duty_act));

  p_idle_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && per_we_i |=> per_act == $past(per_wdata_i));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == '0);

  p_zero_duty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && duty_act == '0 |=> pwm_o == !$past(pol_i));

  p_idle_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> pwm_o == !$past(pol_i));
endmodule

bind pwm_chan pwm_chan_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_q(en_q), .pol_i(pol_i),
  .per_we_i(per_we_i), .per_wdata_i(per_wdata_i), .cnt_we_i(cnt_we_i),
  .reload(reload), .per_act(per_act), .duty_act(duty_act),
  .cnt_o(cnt_o), .pwm_o(pwm_o)
);

// File: tb/tb_pwm_chan.sv
module tb_pwm_chan;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, en_i = 1'b0, pol_i = 1'b0, center_i = 1'b0;
  logic       per_we_i = 1'b0, duty_we_i = 1'b0, cnt_we_i = 1'b0;
  logic [7:0] per_wdata_i = '0, duty_wdata_i = '0;
  logic [7:0] cnt_o;
  logic       pwm_o;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [7:0] m_cnt = '0, m_pbuf = '0, m_pact = '0, m_dbuf = '0, m_dact = '0;
  logic       m_up = 1'b1, m_en = 1'b0, m_pwm = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_chan dut (
    .clk_i, .rst_ni, .tick_i, .en_i, .pol_i, .center_i,
    .per_we_i, .per_wdata_i, .duty_we_i, .duty_wdata_i, .cnt_we_i,
    .cnt_o, .pwm_o
  );

  function automatic logic is_active(logic [7:0] c, logic [7:0] p, logic [7:0] d);
    return (d != 0) && ((c < d) || (d >= p));
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: advance model from current inputs, then compare
  task automatic cyc(string tag);
    logic [7:0] n_cnt, n_pbuf, n_dbuf, n_pact, n_dact;
    logic n_up, n_en, n_pwm, wrap;
    n_cnt = m_cnt; n_up = m_up; wrap = 1'b0;
    if (cnt_we_i) begin
      n_cnt = 0; n_up = 1'b1; wrap = 1'b1;
    end else if (tick_i && m_en) begin
      if (!center_i) begin
        if (m_cnt >= m_pact) begin n_cnt = 0; wrap = 1'b1; end
        else n_cnt = m_cnt + 8'd1;
      end else if (m_up && m_cnt < m_pact) n_cnt = m_cnt + 8'd1;
      else if (m_cnt <= 1) begin n_cnt = 0; n_up = 1'b1; wrap = 1'b1; end
      else begin n_cnt = m_cnt - 8'd1; n_up = 1'b0; end
    end
    n_en   = tick_i ? en_i : m_en;
    n_pwm  = (m_en && is_active(m_cnt, m_pact, m_dact)) ? pol_i : !pol_i;
    n_pbuf = per_we_i ? per_wdata_i : m_pbuf;
    n_dbuf = duty_we_i ? duty_wdata_i : m_dbuf;
    n_pact = !m_en ? n_pbuf : (wrap ? m_pbuf : m_pact);
    n_dact = !m_en ? n_dbuf : (wrap ? m_dbuf : m_dact);
    @(posedge clk_i); #1;
    m_cnt = n_cnt; m_up = n_up; m_en = n_en; m_pwm = n_pwm;
    m_pbuf = n_pbuf; m_dbuf = n_dbuf; m_pact = n_pact; m_dact = n_dact;
    check({tag, " R11"}, cnt_o, m_cnt, "cnt_o");
    check(tag, {7'd0, pwm_o}, {7'd0, m_pwm}, "pwm_o");
  endtask

  task automatic wr(logic pw, logic [7:0] p, logic dw, logic [7:0] d, string tag);
    per_we_i = pw; per_wdata_i = p; duty_we_i = dw; duty_wdata_i = d;
    cyc(tag);
    per_we_i = 1'b0; duty_we_i = 1'b0;
  endtask

  task automatic run(int n, int div, string tag);
    for (int k = 0; k < n; k++) begin
      tick_i = (k % div == 0);
      cyc(tag);
    end
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog R1..: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int per_list [5] = '{0, 1, 2, 3, 6};
    string tg;
    #(CLK_PERIOD * 2 + 1);
    check("reset", cnt_o, 8'd0, "cnt_o");
    check("reset R10", {7'd0, pwm_o}, 8'd0, "pwm_o");
    rst_ni = 1'b1;
    #(CLK_PERIOD - 1);

    // sweep: alignment x polarity x period x duty, R3 R7 R8 R9
    for (int c = 0; c < 2; c++)
      for (int pl = 0; pl < 2; pl++)
        for (int pi = 0; pi < 5; pi++)
          for (int d = 0; d <= per_list[pi] + 1; d++) begin
            int p = per_list[pi];
            int div = 1 + 2 * (d % 2);
            center_i = c[0]; pol_i = pl[0];
            en_i = 1'b0; tick_i = 1'b1;
            cyc("R10"); cyc("R10");
            tick_i = 1'b0;
            wr(1'b1, 8'(p), 1'b1, 8'(d), "R5");
            cnt_we_i = 1'b1; cyc("R6"); cnt_we_i = 1'b0;
            en_i = 1'b1;
            if (d == 0 || d >= p) tg = c ? "R3 R8 R9" : "R3 R7 R9";
            else                  tg = c ? "R3 R8" : "R3 R7";
            run((2 * p + 3) * 2 * div, div, tg);
          end

    // R4: write while enabled, old values kept until wrap
    center_i = 1'b0; pol_i = 1'b1; en_i = 1'b0; tick_i = 1'b1;
    cyc("R10"); tick_i = 1'b0;
    wr(1'b1, 8'd5, 1'b1, 8'd2, "R5");
    en_i = 1'b1;
    run(3, 1, "R4");
    wr(1'b1, 8'd3, 1'b1, 8'd3, "R4");
    run(14, 1, "R4");
    center_i = 1'b1;
    wr(1'b0, 8'd0, 1'b1, 8'd1, "R4 R8");
    run(14, 1, "R4 R8");

    // R6: counter write in mid-period forces reload
    center_i = 1'b0;
    run(2, 1, "R6");
    wr(1'b1, 8'd7, 1'b1, 8'd4, "R6");
    run(1, 1, "R6");
    cnt_we_i = 1'b1; cyc("R6"); cnt_we_i = 1'b0;
    run(12, 1, "R6");

    // R1 R10: disable mid-count, counter holds, pin idles
    en_i = 1'b0; tick_i = 1'b1; cyc("R1"); tick_i = 1'b0;
    run(9, 1, "R1 R10");
    wr(1'b1, 8'd2, 1'b1, 8'd1, "R5");
    run(3, 1, "R1 R5");

    // R2: enable without tick does nothing, then takes effect on tick
    en_i = 1'b1;
    for (int k = 0; k < 4; k++) begin tick_i = 1'b0; cyc("R2"); end
    run(10, 2, "R2 R5");
    en_i = 1'b0;
    for (int k = 0; k < 3; k++) begin tick_i = 1'b0; cyc("R2"); end
    tick_i = 1'b1; cyc("R2"); tick_i = 1'b0;
    run(4, 1, "R2 R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule